// File: doc/BRIEF.md
# Burst ROM Read Sequencer

This block runs reads from an external mask ROM on a single chip-select space. The ROM port is either 8 or 16 bits wide. A host asks for a byte, word or longword with a one-cycle request pulse. The block breaks the request into ROM-width beats. Each beat waits a programmable number of cycles before its data is sampled. The sampled bytes are packed into a 32-bit result, which is returned with a one-cycle acknowledge.

Some ROMs can serve the next location of a four-address group without a fresh select. For these ROMs a burst mode can be enabled. When a request qualifies, chip select and the read strobe stay active from the first beat to the last, and only the low address bits move. Every beat after the first then skips its address setup cycle and takes one cycle less. Requests that do not qualify, and all requests when burst mode is off, use ordinary beats.

Top module: `brom_burst_ctrl`

## Requirements
- R1: While reset is asserted, and from reset onward until a request arrives, `rom_cs_n` and `rom_rd_n` are 1 and `ack` is 0. Asserting reset during a transfer returns both strobes to 1 at once.
- R2: The beat count comes from `req_size` and the port width. `req_size` encodes 0 = byte, 1 = word, and 2 or 3 = longword. An 8-bit port takes 1, 2 or 4 beats. A 16-bit port (`cfg_port16`=1) takes 1 beat for a byte or word and 2 beats for a longword. Beat k drives the request address with its two low bits replaced by (low bits + k) mod 4 on an 8-bit port, or by (low bits + 2k) mod 4 on a 16-bit port.
- R3: An ordinary beat has three parts. First comes one setup cycle with the beat address driven and `rom_cs_n`=`rom_rd_n`=1. Then come `cfg_wait` wait cycles, followed by one strobe cycle. During the wait and strobe cycles both strobes are 0, and data is sampled at the end of the strobe cycle. Chip select returns to 1 between ordinary beats.
- R4: A request bursts only if three things hold: `cfg_burst_en`=1, it needs more than one beat, and it is either a word or longword on an 8-bit port or a longword on a 16-bit port. Otherwise chip select returns to 1 after each beat.
- R5: In a burst the first beat is ordinary. Every later beat has no setup cycle: chip select stays 0 and the address changes while it is low. Each later beat is therefore one cycle shorter than an ordinary one.
- R6: Bytes are packed big-endian, with the lowest address in the most significant position, and right-justified with zero extension. For a byte read on a 16-bit port, `rom_data[15:8]` is taken at an even address and `rom_data[7:0]` at an odd one.
- R7: `ack` is high for exactly one cycle, the cycle after the last strobe cycle. `rdata` is valid in that cycle and both strobes are already 1.
- R8: A request pulse that arrives while a transfer is in progress is ignored. It starts no later transfer and does not change the running one.
- R9: A wait setting of 0 gives beats made of only a strobe cycle, plus the setup cycle where one applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_en | input | 1 | Enable burst beats for qualifying requests |
| cfg_port16 | input | 1 | ROM port width: 1 = 16 bits, 0 = 8 bits |
| cfg_wait | input | WAIT_W | Wait cycles per beat |
| req | input | 1 | One-cycle read request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, valid with ack |
| rom_addr | output | ADDR_W | ROM address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_data | input | 16 | ROM data bus |

## Verification
Twelve table transfers cover both port widths, all three sizes and wait settings of 0, 1, 2, 3 and 5, each with burst mode on and off. The measured latency and the count of chip-select releases separate burst beats from ordinary ones. They also show whether qualification was applied for the right size and width pairs. The ROM model returns data that depends on the address, so the packed result exposes wrong beat addresses, wrong byte order and wrong lane choice. Directed cases add a request pulse during a busy transfer, which must be dropped, and a reset in mid-transfer, which must release the strobes at once.

// File: rtl/brom_pkg.sv
`timescale 1ns/1ps
package brom_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } xfer_size_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_STROBE,
    ST_DONE
  } seq_state_t;

  localparam int BEAT_W = 2;
endpackage

// File: rtl/brom_beat_plan.sv
`timescale 1ns/1ps
module brom_beat_plan
  import brom_pkg::*;
(
  input  logic              port16,
  input  logic              burst_en,
  input  logic [1:0]        size,
  output logic [BEAT_W-1:0] last_idx,
  output logic              burst_ok
);
  logic is_byte;
  logic is_long;

  assign is_byte = (size == SZ_BYTE);
  assign is_long = size[1];

  always_comb begin
    if (port16) begin
      last_idx = is_long ? BEAT_W'(1) : BEAT_W'(0);
    end else if (is_long) begin
      last_idx = BEAT_W'(3);
    end else if (is_byte) begin
      last_idx = BEAT_W'(0);
    end else begin
      last_idx = BEAT_W'(1);
    end
  end

  // multi-beat qualifying cases only
  assign burst_ok = burst_en & (port16 ? is_long : ~is_byte);
endmodule

// File: rtl/brom_wait_timer.sv
`timescale 1ns/1ps
module brom_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              last
);
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_d;
  logic              cnt_en;

  assign cnt_en = load | run;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/brom_data_pack.sv
`timescale 1ns/1ps
module brom_data_pack #(
  parameter int DATA_W = 32,
  parameter int ROM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              capture,
  input  logic              port16,
  input  logic              byte_req,
  input  logic              lane_odd,
  input  logic [ROM_W-1:0]  rom_data,
  output logic [DATA_W-1:0] data
);
  localparam int HALF_W = ROM_W / 2;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic [HALF_W-1:0] lane_byte;
  logic              acc_en;

  assign lane_byte = lane_odd ? rom_data[HALF_W-1:0] : rom_data[ROM_W-1:HALF_W];
  assign acc_en    = clr | capture;

  always_comb begin
    if (clr) begin
      acc_d = '0;
    end else if (port16 && !byte_req) begin
      acc_d = {acc_q[DATA_W-ROM_W-1:0], rom_data};
    end else if (port16) begin
      acc_d = {acc_q[DATA_W-HALF_W-1:0], lane_byte};
    end else begin
      acc_d = {acc_q[DATA_W-HALF_W-1:0], rom_data[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign data = acc_q;
endmodule

// File: rtl/brom_burst_ctrl.sv
`timescale 1ns/1ps
module brom_burst_ctrl
  import brom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_burst_en,
  input  logic              cfg_port16,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  input  logic [15:0]       rom_data
);
  localparam int DATA_W = 32;
  localparam int ROM_W  = 16;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        size_q;
  logic              port16_q;
  logic              burst_q;
  logic [WAIT_W-1:0] wait_q;
  logic [BEAT_W-1:0] last_q;
  logic [BEAT_W-1:0] beat_q;

  logic [BEAT_W-1:0] plan_last;
  logic              plan_burst;
  logic              accept;
  logic              tmr_load;
  logic              tmr_run;
  logic              tmr_last;
  logic              capture;
  logic              beat_inc;
  logic              wait_zero;
  logic              final_beat;
  logic              busy;
  logic [1:0]        addr_step;

  brom_beat_plan i_plan (
    .port16   (cfg_port16),
    .burst_en (cfg_burst_en),
    .size     (req_size),
    .last_idx (plan_last),
    .burst_ok (plan_burst)
  );

  brom_wait_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (tmr_load),
    .load_val (wait_q),
    .run      (tmr_run),
    .last     (tmr_last)
  );

  brom_data_pack #(.DATA_W(DATA_W), .ROM_W(ROM_W)) i_pack (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr      (accept),
    .capture  (capture),
    .port16   (port16_q),
    .byte_req (size_q == SZ_BYTE),
    .lane_odd (base_q[0]),
    .rom_data (rom_data),
    .data     (rdata)
  );

  assign wait_zero  = (wait_q == '0);
  assign final_beat = (beat_q == last_q);
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    capture  = 1'b0;
    beat_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        tmr_load = ~wait_zero;
        state_d  = wait_zero ? ST_STROBE : ST_WAIT;
      end
      ST_WAIT: begin
        tmr_run = 1'b1;
        if (tmr_last) state_d = ST_STROBE;
      end
      ST_STROBE: begin
        capture = 1'b1;
        if (final_beat) begin
          state_d = ST_DONE;
        end else begin
          beat_inc = 1'b1;
          if (burst_q) begin
            tmr_load = ~wait_zero;
            state_d  = wait_zero ? ST_STROBE : ST_WAIT;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      size_q   <= '0;
      port16_q <= 1'b0;
      burst_q  <= 1'b0;
      wait_q   <= '0;
      last_q   <= '0;
      beat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        base_q   <= req_addr;
        size_q   <= req_size;
        port16_q <= cfg_port16;
        burst_q  <= plan_burst;
        wait_q   <= cfg_wait;
        last_q   <= plan_last;
        beat_q   <= '0;
      end else if (beat_inc) begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end

  // beat offset inside the four-address group
  assign addr_step = port16_q ? {beat_q[0], 1'b0} : beat_q;
  assign rom_addr  = {base_q[ADDR_W-1:2], base_q[1:0] + addr_step};

  assign rom_cs_n = ~((state_q == ST_WAIT) | (state_q == ST_STROBE));
  assign rom_rd_n = ~((state_q == ST_WAIT) | (state_q == ST_STROBE));
  assign ack      = (state_q == ST_DONE);
endmodule

// File: rtl/brom_burst_ctrl_chk.sv
`timescale 1ns/1ps
module brom_burst_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ack,
  input logic              rom_cs_n,
  input logic              rom_rd_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              busy,
  input logic              burst_q,
  input logic [ADDR_W-1:0] base_q
);
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_strobes_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (rom_cs_n && rom_rd_n));

  assert_rd_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_rd_n |-> !rom_cs_n);

  assert_setup_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_cs_n) |-> ($past(rom_rd_n) && $stable(rom_addr)));

  assert_addr_moves_low_only_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !$past(rom_cs_n) && (rom_addr != $past(rom_addr))) |-> burst_q);

  assert_busy_req_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> $stable(base_q));
endmodule

bind brom_burst_ctrl brom_burst_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .ack      (ack),
  .rom_cs_n (rom_cs_n),
  .rom_rd_n (rom_rd_n),
  .rom_addr (rom_addr),
  .busy     (busy),
  .burst_q  (burst_q),
  .base_q   (base_q)
);

// File: tb/test_brom_burst_ctrl.sv
`timescale 1ns/1ps
module test_brom_burst_ctrl;
  localparam int AW = 24;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_burst_en;
  logic          cfg_port16;
  logic [WW-1:0] cfg_wait;
  logic          req;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          ack;
  logic [31:0]   rdata;
  logic [AW-1:0] rom_addr;
  logic          rom_cs_n;
  logic          rom_rd_n;
  logic [15:0]   rom_data;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  brom_burst_ctrl #(.ADDR_W(AW), .WAIT_W(WW)) i_brom_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_burst_en(cfg_burst_en), .cfg_port16(cfg_port16),
    .cfg_wait(cfg_wait), .req(req), .req_addr(req_addr), .req_size(req_size),
    .ack(ack), .rdata(rdata), .rom_addr(rom_addr), .rom_cs_n(rom_cs_n),
    .rom_rd_n(rom_rd_n), .rom_data(rom_data)
  );

  function automatic logic [7:0] rom8(input logic [AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C ^ a[15:8];
  endfunction

  assign rom_data = cfg_port16 ? {rom8({rom_addr[AW-1:1], 1'b0}), rom8({rom_addr[AW-1:1], 1'b1})}
                               : {8'h00, rom8(rom_addr)};

  // R2 R6: bytes at consecutive addresses, wrapping in the group, big-endian
  function automatic logic [31:0] exp_data(input logic [AW-1:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < nb; k++) r = {r[23:0], rom8({a[AW-1:2], a[1:0] + 2'(k)})};
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       p16;
    logic       bst;
    logic [3:0] w;
    logic [1:0] sz;
    logic [23:0] a;
    logic [7:0] lat;
    logic [2:0] brk;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd2, 2'd2, 24'h000100, 8'd17, 3'd4},  // 8-bit long ordinary
    '{1'b0, 1'b1, 4'd2, 2'd2, 24'h000100, 8'd14, 3'd1},  // 8-bit long burst
    '{1'b0, 1'b1, 4'd2, 2'd1, 24'h000102, 8'd8,  3'd1},  // 8-bit word burst
    '{1'b0, 1'b1, 4'd2, 2'd0, 24'h000103, 8'd5,  3'd1},  // byte never bursts
    '{1'b1, 1'b1, 4'd2, 2'd2, 24'h000200, 8'd8,  3'd1},  // 16-bit long burst
    '{1'b1, 1'b1, 4'd2, 2'd1, 24'h000202, 8'd5,  3'd1},  // 16-bit word single
    '{1'b1, 1'b0, 4'd2, 2'd2, 24'h000204, 8'd9,  3'd2},  // 16-bit long ordinary
    '{1'b0, 1'b1, 4'd0, 2'd2, 24'h000010, 8'd6,  3'd1},  // R9 zero wait burst
    '{1'b0, 1'b0, 4'd0, 2'd1, 24'h000012, 8'd5,  3'd2},  // R9 zero wait ordinary
    '{1'b1, 1'b1, 4'd5, 2'd2, 24'h000300, 8'd14, 3'd1},  // long waits
    '{1'b1, 1'b0, 4'd1, 2'd0, 24'h000301, 8'd4,  3'd1},  // odd byte lane
    '{1'b0, 1'b1, 4'd3, 2'd2, 24'h000104, 8'd18, 3'd1}   // 8-bit long burst, 3 waits
  };

  task automatic pulse_req(input logic [AW-1:0] a, input logic [1:0] sz);
    req_addr = a;
    req_size = sz;
    req      = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int   lat  = 1;
    int   brk  = 0;
    logic prev = 1'b1;
    @(negedge clk);
    cfg_port16   = v.p16;
    cfg_burst_en = v.bst;
    cfg_wait     = v.w;
    pulse_req(v.a, v.sz);
    // first cycle after acceptance is the setup cycle
    check(rom_cs_n && rom_rd_n && (rom_addr == v.a), "R3 setup cycle",
          {7'b0, rom_cs_n, rom_addr}, {8'h01, v.a});
    prev = rom_cs_n;
    while (!ack && lat < 200) begin
      @(negedge clk);
      lat++;
      if (!prev && rom_cs_n) brk++;
      prev = rom_cs_n;
    end
    check(lat == int'(v.lat), v.bst ? "R5 latency" : "R3 latency", 32'(lat), 32'(v.lat));
    check(brk == int'(v.brk), "R4 chip-select releases", 32'(brk), 32'(v.brk));
    check(rdata == exp_data(v.a, v.sz), "R2 R6 data", rdata, exp_data(v.a, v.sz));
    check(rom_cs_n && rom_rd_n, "R7 strobes off at ack", {rom_cs_n, rom_rd_n}, 32'h3);
    @(negedge clk);
    check(!ack, "R7 ack width", 32'(ack), 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int acks;
    int cs_low;
    logic [31:0] first;
    rst_n = 1'b0; req = 1'b0; req_addr = '0; req_size = '0;
    cfg_burst_en = 1'b0; cfg_port16 = 1'b0; cfg_wait = 4'd2;
    repeat (3) @(negedge clk);
    check(rom_cs_n && rom_rd_n && !ack, "R1 reset state",
          {ack, rom_cs_n, rom_rd_n}, 32'h3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rom_cs_n && rom_rd_n && !ack, "R1 idle after reset",
          {ack, rom_cs_n, rom_rd_n}, 32'h3);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: request pulse during a busy transfer is dropped
    @(negedge clk);
    cfg_port16 = 1'b0; cfg_burst_en = 1'b0; cfg_wait = 4'd2;
    pulse_req(24'h000100, 2'd2);
    repeat (3) @(negedge clk);
    pulse_req(24'h0002F0, 2'd0);
    acks = 0; cs_low = 0; first = '0;
    for (int c = 0; c < 40; c++) begin
      if (ack) begin
        if (acks == 0) first = rdata;
        acks++;
      end else if (acks > 0 && !rom_cs_n) begin
        cs_low++;
      end
      @(negedge clk);
    end
    check(acks == 1, "R8 single ack", 32'(acks), 32'd1);
    check(first == exp_data(24'h000100, 2'd2), "R8 running transfer intact",
          first, exp_data(24'h000100, 2'd2));
    check(cs_low == 0, "R8 no extra transfer", 32'(cs_low), 32'd0);

    // R1: reset in mid-transfer releases strobes at once
    pulse_req(24'h000100, 2'd2);
    repeat (2) @(negedge clk);
    check(!rom_cs_n, "R1 transfer running before reset", 32'(rom_cs_n), 32'h0);
    rst_n = 1'b0;
    #1;
    check(rom_cs_n && rom_rd_n && !ack, "R1 async reset mid-transfer",
          {ack, rom_cs_n, rom_rd_n}, 32'h3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(VECS[1]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule